// File: doc/BRIEF.md
# Input Persistency Filter

This block watches a group of digital input lines and turns level changes on them into change-interrupt requests. A free-running prescaler turns the system clock into a sample tick, nominally one every 32 µs. All lines are sampled only on that tick. Each of the `NCH` channels carries two filtered inputs, A and B. Input A takes its minimum stable time from `dur_a` and input B takes it from `dur_b`. The minimum stable time is the register value times 64 µs, which is two sample ticks per unit. A new level must be seen on that many consecutive samples before it is accepted. A shorter excursion is thrown away. A register value of zero turns the filter off, so the first sampled change is accepted.

The filtered inputs come from one of two places, chosen by `static_mode`. In static mode, channel c reads its own pins `pin_a[c]` and `pin_b[c]`. In dynamic mode, all channels share the two lines `mux_a` and `mux_b`, and `slot` names the channel whose values are present on those lines. Only that channel samples on the tick. Every channel keeps its own counter state, so interleaved samples from the other channels do not disturb it.

A separate set of `NL` plain lines has no filtering and raises a request on the first sampled change. A mask bit suppresses a request. A plain line configured as an output never raises a request, whatever its mask bit holds.

Top module: `input_persist_filter`

## Requirements
- R1: While `rst_n` is low and after it is released with all inputs at 0, `lvl_a`, `lvl_b`, `chg_a`, `chg_b`, `chan_req` and `line_req` are all 0. The accepted levels reset to 0.
- R2: Inputs are sampled only on a tick, which comes every `TICK_DIV` clocks. With a zero duration, a change driven on a line shows on the outputs after 1 to `TICK_DIV` clock edges.
- R3: With a duration value D > 0, a new level is accepted on the 2·D-th consecutive tick sample that differs from the accepted level. The change pulse appears after (2·D−1)·`TICK_DIV`+1 to 2·D·`TICK_DIV` clock edges.
- R4: A level that returns before 2·D consecutive differing samples produces no change pulse and no request, and the accepted level stays as it was.
- R5: With a duration value of 0, a single differing sample is enough to accept the new level.
- R6: Inputs A use `dur_a` and inputs B use `dur_b`, each on its own.
- R7: When `static_mode`=1, channel c filters `pin_a[c]`/`pin_b[c]`, and `mux_a`/`mux_b` have no effect.
- R8: When `static_mode`=0, only the channel whose index equals `slot` samples `mux_a`/`mux_b` on a tick. The `pin_*` lines have no effect. Each channel counts only its own samples.
- R9: On acceptance, `lvl_a[c]`/`lvl_b[c]` takes the new level and `chg_a[c]`/`chg_b[c]` is high for exactly one clock. `chan_req[c]` is high in the same clock unless the channel is masked.
- R10: With `chan_mask[c]`=1, channel c raises no `chan_req`, but its filtering and accepted levels still update.
- R11: A plain line with `line_dir_out`=0 and `line_mask`=0 raises `line_req` for one clock after each sampled change, with no filtering.
- R12: A plain line with `line_dir_out`=1 never raises `line_req`, whatever its mask bit holds.
- R13: A plain line with `line_mask`=1 raises no `line_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| static_mode | input | 1 | 1: each channel has its own pins; 0: shared multiplexed lines |
| dur_a | input | 8 | Minimum stable time for A inputs, in units of two ticks |
| dur_b | input | 8 | Minimum stable time for B inputs, in units of two ticks |
| slot | input | log2(NCH) | Channel whose values are on the shared lines (dynamic mode) |
| mux_a | input | 1 | Shared A line |
| mux_b | input | 1 | Shared B line |
| pin_a | input | NCH | Per-channel A lines (static mode) |
| pin_b | input | NCH | Per-channel B lines (static mode) |
| chan_mask | input | NCH | 1 suppresses the channel's request |
| line_in | input | NL | Plain, unfiltered lines |
| line_dir_out | input | NL | 1 marks the plain line as an output |
| line_mask | input | NL | 1 suppresses the plain line's request |
| lvl_a | output | NCH | Accepted A levels |
| lvl_b | output | NCH | Accepted B levels |
| chg_a | output | NCH | One-clock pulse when an A level is accepted |
| chg_b | output | NCH | One-clock pulse when a B level is accepted |
| chan_req | output | NCH | Per-channel request pulse after masking |
| line_req | output | NL | Plain-line request pulse after direction and mask gating |

## Verification
The hardest case to reach is dynamic mode. There, one channel's filter must count only the samples taken while the slot names it, with other channels' samples coming in between. That only works if the slot changes exactly between ticks. The bench first locks onto the tick phase: it toggles a plain line and waits for the request pulse, which marks the tick edge. It then changes `slot` once per tick and drives the shared line high only in channel 0's slots. Channel 0 must accept after four of its own samples, and channel 1 must stay quiet.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  localparam int DUR_W = 8;
  localparam int CNT_W = DUR_W + 1;

  // Consecutive differing samples needed before a new level is taken.
  // Each duration unit spans two sample ticks; zero means one sample.
  function automatic logic [CNT_W-1:0] needed_samples(input logic [DUR_W-1:0] dur);
    if (dur == '0) needed_samples = CNT_W'(1);
    else           needed_samples = {dur, 1'b0};
  endfunction
endpackage

// File: rtl/ipf_tick_gen.sv
module ipf_tick_gen #(
  parameter int DIV = 4000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/ipf_stab_filter.sv
module ipf_stab_filter
  import ipf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             din,
  input  logic [DUR_W-1:0] dur,
  output logic             lvl,
  output logic             take,
  output logic             chg
);
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] need;
  logic             differs;

  assign need    = needed_samples(dur);
  assign differs = din ^ lvl;
  assign take    = sample_en & differs & ((run + 1'b1) >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      chg <= 1'b0;
      run <= '0;
    end else begin
      chg <= take;
      if (take) begin
        lvl <= din;
        run <= '0;
      end else if (sample_en) begin
        run <= differs ? run + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/ipf_line_watch.sv
module ipf_line_watch #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] dir_out,
  input  logic [NL-1:0] mask,
  output logic [NL-1:0] line_evt,
  output logic [NL-1:0] req
);
  logic [NL-1:0] prev;

  assign line_evt = tick ? (lines ^ prev) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      req  <= '0;
    end else begin
      req <= line_evt & ~dir_out & ~mask;
      if (tick) prev <= lines;
    end
  end
endmodule

// File: rtl/input_persist_filter.sv
module input_persist_filter
  import ipf_pkg::*;
#(
  parameter int TICK_DIV = 4000,
  parameter int NCH      = 4,
  parameter int NL       = 8,
  localparam int SW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             static_mode,
  input  logic [DUR_W-1:0] dur_a,
  input  logic [DUR_W-1:0] dur_b,
  input  logic [SW-1:0]    slot,
  input  logic             mux_a,
  input  logic             mux_b,
  input  logic [NCH-1:0]   pin_a,
  input  logic [NCH-1:0]   pin_b,
  input  logic [NCH-1:0]   chan_mask,
  input  logic [NL-1:0]    line_in,
  input  logic [NL-1:0]    line_dir_out,
  input  logic [NL-1:0]    line_mask,
  output logic [NCH-1:0]   lvl_a,
  output logic [NCH-1:0]   lvl_b,
  output logic [NCH-1:0]   chg_a,
  output logic [NCH-1:0]   chg_b,
  output logic [NCH-1:0]   chan_req,
  output logic [NL-1:0]    line_req
);
  logic           tick;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] take_a;
  logic [NCH-1:0] take_b;
  logic [NL-1:0]  line_evt;

  ipf_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic src_a;
    logic src_b;

    assign ch_en[c] = tick & (static_mode | (slot == SW'(c)));
    assign src_a    = static_mode ? pin_a[c] : mux_a;
    assign src_b    = static_mode ? pin_b[c] : mux_b;

    ipf_stab_filter u_fa (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(ch_en[c]),
      .din      (src_a),
      .dur      (dur_a),
      .lvl      (lvl_a[c]),
      .take     (take_a[c]),
      .chg      (chg_a[c])
    );

    ipf_stab_filter u_fb (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(ch_en[c]),
      .din      (src_b),
      .dur      (dur_b),
      .lvl      (lvl_b[c]),
      .take     (take_b[c]),
      .chg      (chg_b[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_req <= '0;
    else        chan_req <= (take_a | take_b) & ~chan_mask;
  end

  ipf_line_watch #(.NL(NL)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .lines   (line_in),
    .dir_out (line_dir_out),
    .mask    (line_mask),
    .line_evt(line_evt),
    .req     (line_req)
  );
endmodule

// File: rtl/input_persist_filter_chk.sv
module input_persist_filter_chk #(
  parameter int NCH = 4,
  parameter int NL  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           static_mode,
  input logic           tick,
  input logic [NCH-1:0] lvl_a,
  input logic [NCH-1:0] lvl_b,
  input logic [NCH-1:0] chg_a,
  input logic [NCH-1:0] chg_b,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] chan_mask,
  input logic [NL-1:0]  line_req,
  input logic [NL-1:0]  line_dir_out,
  input logic [NL-1:0]  line_mask
);
  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (((chg_a | chg_b) != '0) || (line_req != '0)) |-> $past(tick)); // R2

  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_a | chg_b) != '0) |=> (((chg_a | chg_b) & $past(chg_a | chg_b)) == '0)); // R9

  AST_LVL_A_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_a ^ $past(lvl_a)) == chg_a)); // R9

  AST_LVL_B_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_b ^ $past(lvl_b)) == chg_b)); // R9

  AST_REQ_NEEDS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_req & ~(chg_a | chg_b)) == '0)); // R9

  AST_CHAN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_req & $past(chan_mask)) == '0)); // R10

  AST_DYN_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!static_mode) |-> ($countones(chg_a) <= 1 && $countones(chg_b) <= 1)); // R8

  AST_OUT_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_req & $past(line_dir_out)) == '0)); // R12

  AST_LINE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_req & $past(line_mask)) == '0)); // R13
endmodule

bind input_persist_filter input_persist_filter_chk #(.NCH(NCH), .NL(NL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .static_mode (static_mode),
  .tick        (tick),
  .lvl_a       (lvl_a),
  .lvl_b       (lvl_b),
  .chg_a       (chg_a),
  .chg_b       (chg_b),
  .chan_req    (chan_req),
  .chan_mask   (chan_mask),
  .line_req    (line_req),
  .line_dir_out(line_dir_out),
  .line_mask   (line_mask)
);

// File: tb/tb_input_persist_filter.sv
`timescale 1ns/1ps
module tb_input_persist_filter;
  localparam int DIV = 4;
  localparam int NCH = 4;
  localparam int NL  = 4;
  localparam int NV  = 8;

  // {channel[19:18], use_b[17], duration[16:9], held_ticks[8:1], accepted[0]}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'd0, 8'd1,  1'b1},
    {2'd1, 1'b0, 8'd1, 8'd1,  1'b0},
    {2'd1, 1'b0, 8'd1, 8'd2,  1'b1},
    {2'd2, 1'b1, 8'd3, 8'd5,  1'b0},
    {2'd2, 1'b1, 8'd3, 8'd6,  1'b1},
    {2'd3, 1'b1, 8'd2, 8'd3,  1'b0},
    {2'd3, 1'b0, 8'd5, 8'd10, 1'b1},
    {2'd0, 1'b1, 8'd5, 8'd9,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic static_mode = 1'b1;
  logic [7:0] dur_a = '0, dur_b = '0;
  logic [1:0] slot = '0;
  logic mux_a = 1'b0, mux_b = 1'b0;
  logic [NCH-1:0] pin_a = '0, pin_b = '0, chan_mask = '0;
  logic [NL-1:0] line_in = '0, line_dir_out = '0, line_mask = '0;
  logic [NCH-1:0] lvl_a, lvl_b, chg_a, chg_b, chan_req;
  logic [NL-1:0] line_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int n_ca [NCH], n_cb [NCH], n_rq [NCH], n_ln [NL];

  always #4 clk = ~clk;

  input_persist_filter #(.TICK_DIV(DIV), .NCH(NCH), .NL(NL)) dut (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .dur_a(dur_a), .dur_b(dur_b),
    .slot(slot), .mux_a(mux_a), .mux_b(mux_b), .pin_a(pin_a), .pin_b(pin_b),
    .chan_mask(chan_mask), .line_in(line_in), .line_dir_out(line_dir_out),
    .line_mask(line_mask), .lvl_a(lvl_a), .lvl_b(lvl_b), .chg_a(chg_a), .chg_b(chg_b),
    .chan_req(chan_req), .line_req(line_req)
  );

  initial begin
    for (int i = 0; i < NCH; i++) begin n_ca[i] = 0; n_cb[i] = 0; n_rq[i] = 0; end
    for (int i = 0; i < NL; i++) n_ln[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (chg_a[i] === 1'b1) n_ca[i]++;
      if (chg_b[i] === 1'b1) n_cb[i]++;
      if (chan_req[i] === 1'b1) n_rq[i]++;
    end
    for (int i = 0; i < NL; i++) if (line_req[i] === 1'b1) n_ln[i]++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int need_of(input int d);
    return (d == 0) ? 1 : d * 2;
  endfunction

  function automatic int sum_chg();
    int s = 0;
    for (int i = 0; i < NCH; i++) s += n_ca[i] + n_cb[i];
    return s;
  endfunction

  // Returns at the falling edge right after a tick edge.
  task automatic lock_phase();
    line_dir_out[0] = 1'b0;
    line_mask[0] = 1'b0;
    line_in[0] = ~line_in[0];
    for (int k = 0; k < 4 * DIV; k++) begin
      @(negedge clk);
      if (line_req[0]) break;
    end
  endtask

  initial begin
    int a0, b0, r0, s0, ka, kb, k;
    // Reset state (R1)
    wait_cyc(3);
    check(lvl_a == 0 && lvl_b == 0, "R1 levels in reset", int'({lvl_a, lvl_b}), 0);
    check((chg_a | chg_b | chan_req) == 0 && line_req == 0, "R1 pulses in reset",
          int'({chg_a, chg_b, chan_req, line_req}), 0);
    rst_n = 1'b1;
    wait_cyc(5 * DIV);
    check(sum_chg() == 0 && lvl_a == 0 && lvl_b == 0, "R1 quiet after release", sum_chg(), 0);

    // Table of filter scenarios, static mode (R3 R4 R5 R9)
    for (int v = 0; v < NV; v++) begin
      int ch, useb, d, hold, acc;
      logic orig;
      ch = int'(VEC[v][19:18]); useb = int'(VEC[v][17]); d = int'(VEC[v][16:9]);
      hold = int'(VEC[v][8:1]); acc = int'(VEC[v][0]);
      if (useb != 0) dur_b = 8'(d); else dur_a = 8'(d);
      a0 = useb != 0 ? n_cb[ch] : n_ca[ch];
      r0 = n_rq[ch];
      orig = useb != 0 ? pin_b[ch] : pin_a[ch];
      if (useb != 0) pin_b[ch] = ~orig; else pin_a[ch] = ~orig;
      wait_cyc(hold * DIV);
      if (useb != 0) pin_b[ch] = orig; else pin_a[ch] = orig;
      wait_cyc((need_of(d) + 2) * DIV);
      b0 = (useb != 0 ? n_cb[ch] : n_ca[ch]) - a0;
      check(b0 == (acc != 0 ? 2 : 0), d == 0 ? "R5 zero bypass" : (acc != 0 ? "R3 accepted" : "R4 glitch dropped"),
            b0, acc != 0 ? 2 : 0);
      check((n_rq[ch] - r0) == b0, "R9 request per accept", n_rq[ch] - r0, b0);
      check((useb != 0 ? lvl_b[ch] : lvl_a[ch]) == orig, "R4 level restored",
            int'(useb != 0 ? lvl_b[ch] : lvl_a[ch]), int'(orig));
    end

    // Sampling latency, zero duration (R2)
    dur_a = 8'd0;
    pin_a[0] = 1'b1; k = 0;
    for (int i = 0; i < 4 * DIV; i++) begin @(negedge clk); k++; if (chg_a[0]) break; end
    check(k >= 1 && k <= DIV, "R2 tick latency", k, DIV);
    // Threshold latency D=3 (R3)
    dur_a = 8'd3;
    pin_a[0] = 1'b0; k = 0;
    for (int i = 0; i < 10 * DIV; i++) begin @(negedge clk); k++; if (chg_a[0]) break; end
    check(k >= 5 * DIV + 1 && k <= 6 * DIV, "R3 threshold latency", k, 6 * DIV);

    // Independent A/B durations (R6)
    dur_a = 8'd1; dur_b = 8'd4;
    pin_a[1] = 1'b1; pin_b[1] = 1'b1; ka = 0; kb = 0;
    for (int i = 1; i <= 12 * DIV; i++) begin
      @(negedge clk);
      if (chg_a[1] && ka == 0) ka = i;
      if (chg_b[1] && kb == 0) kb = i;
    end
    check(ka >= DIV + 1 && ka <= 2 * DIV, "R6 A uses dur_a", ka, 2 * DIV);
    check(kb >= 7 * DIV + 1 && kb <= 8 * DIV, "R6 B uses dur_b", kb, 8 * DIV);

    // Shared lines ignored in static mode (R7)
    dur_a = 8'd0; dur_b = 8'd0;
    pin_a = '0; pin_b = '0;
    wait_cyc(4 * DIV);
    s0 = sum_chg();
    mux_a = 1'b1; mux_b = 1'b1;
    wait_cyc(4 * DIV);
    mux_a = 1'b0; mux_b = 1'b0;
    wait_cyc(2 * DIV);
    check(sum_chg() == s0 && lvl_a == 0 && lvl_b == 0, "R7 shared lines ignored", sum_chg() - s0, 0);

    // Dynamic mode: pins ignored, only addressed slot samples (R8)
    static_mode = 1'b0; slot = 2'd2;
    wait_cyc(2 * DIV);
    s0 = sum_chg();
    pin_a = '1; pin_b = '1;
    wait_cyc(4 * DIV);
    check(sum_chg() == s0, "R8 pins ignored in dynamic mode", sum_chg() - s0, 0);
    pin_a = '0; pin_b = '0;
    mux_a = 1'b1;
    wait_cyc(3 * DIV);
    mux_a = 1'b0; slot = 2'd3;
    wait_cyc(DIV);
    check(lvl_a == 4'b0100 && lvl_b == 0, "R8 only slot 2 took shared A", int'(lvl_a), 4);

    // Interleaved slots: channel 0 must count only its own samples (R8)
    dur_a = 8'd2;
    lock_phase();
    a0 = n_ca[0]; b0 = n_ca[1];
    for (int t = 0; t < 8; t++) begin
      slot = 2'(t % 2);
      mux_a = (t % 2 == 0);
      wait_cyc(DIV);
    end
    slot = 2'd3; mux_a = 1'b0;
    wait_cyc(DIV);
    check(n_ca[0] - a0 == 1 && lvl_a[0] == 1'b1, "R8 slot 0 separate count", n_ca[0] - a0, 1);
    check(n_ca[1] - b0 == 0 && lvl_a[1] == 1'b0, "R8 slot 1 untouched", n_ca[1] - b0, 0);

    // Mask keeps request off but filter runs (R10)
    static_mode = 1'b1; dur_a = 8'd0;
    wait_cyc(4 * DIV);
    chan_mask[3] = 1'b1;
    a0 = n_ca[3]; r0 = n_rq[3];
    pin_a[3] = 1'b1;
    wait_cyc(3 * DIV);
    check(n_ca[3] - a0 == 1 && lvl_a[3] == 1'b1, "R10 masked channel still filters", n_ca[3] - a0, 1);
    check(n_rq[3] - r0 == 0, "R10 masked channel no request", n_rq[3] - r0, 0);
    chan_mask[3] = 1'b0;

    // Plain lines (R11 R12 R13)
    a0 = n_ln[1];
    line_in[1] = 1'b1; k = 0;
    for (int i = 0; i < 4 * DIV; i++) begin @(negedge clk); k++; if (line_req[1]) break; end
    check(k >= 1 && k <= DIV, "R11 line request latency", k, DIV);
    wait_cyc(3 * DIV);
    check(n_ln[1] - a0 == 1, "R11 single request", n_ln[1] - a0, 1);
    line_dir_out[2] = 1'b1; a0 = n_ln[2];
    line_in[2] = 1'b1;
    wait_cyc(3 * DIV);
    line_in[2] = 1'b0;
    wait_cyc(3 * DIV);
    check(n_ln[2] - a0 == 0, "R12 output line quiet", n_ln[2] - a0, 0);
    line_mask[3] = 1'b1; a0 = n_ln[3];
    line_in[3] = 1'b1;
    wait_cyc(3 * DIV);
    check(n_ln[3] - a0 == 0, "R13 masked line quiet", n_ln[3] - a0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule